// File: doc/BRIEF.md
# Two-Wire Programming Register Readout

This block sits on the target side of a two-wire serial programming link. The host drives a slow programming clock and a single data line. The data line is bidirectional and is modelled here as a separate input, output and output enable. The host sends 4-bit control codes one bit per clock, least significant bit first. The block acts on only one code, the readout code. On that code it counts a fixed number of idle clocks, takes over the data line, and shifts a 16-bit visibility word from the core out to the host.

Every other code is taken off the wire and discarded. Once the last data bit has been latched, the block drives the line for one more clock so the host can turn the line around cleanly. It then releases the line and waits for the next code. The host clock and data are brought into the system clock domain through a two-flop synchroniser. Edge detection runs on the synchronised clock. The system clock must run at least four times faster than the host clock.

Top module: `pgr_readout`

## Requirements
- R1: While reset is high and after it is released, the output enable is low and the data output is low. The block then waits for the first bit of a control code.
- R2: Control bits are taken on host-clock rising edges, least significant bit first. The four bits on the wire 1,0,0,0 (code value 4'b0001) select the readout. The reversed order 0,0,0,1 does not select it.
- R3: The output enable stays low while the four code bits are received and for the 8 host-clock rising edges that follow the readout code.
- R4: The output enable rises at the first host-clock falling edge after the 8th idle rising edge. The 16 word bits then appear least significant bit first, one per falling edge, and each bit is stable at the next rising edge.
- R5: The word that is sent is the value of the visibility input at the first falling edge of the shift phase. Changes to that input later in the transfer do not alter the bits sent.
- R6: After the 16th bit has been latched, the line stays driven with bit 15 for one further clock. The output enable drops at that clock's rising edge. This turnaround clock carries no code bit, and the next rising edge latches the first bit of the next code.
- R7: A code other than 4'b0001 leaves the output enable low. The very next four rising edges are taken as a fresh code.
- R8: Reset in the middle of a transfer releases the line at once and clears all counters. The next readout then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the host clock |
| rst | input | 1 | Synchronous reset, active high |
| pclk_i | input | 1 | Host programming clock (asynchronous) |
| pdat_i | input | 1 | Data line as seen from the host |
| vis_i | input | 16 | Visibility word supplied by the core |
| pdat_o | output | 1 | Data driven toward the host |
| pdat_oe_o | output | 1 | High while the block drives the data line |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a 16-bit word, 8 idle clocks and a 2-stage synchroniser. The host clock runs at one sixteenth of the system clock. With a 4-bit code, the bench can sweep the whole code space, sending each of the fifteen non-readout codes and following each one straight away with a readout. The 16-bit word is small enough to send all sixteen walking-one patterns plus arithmetic sequences. The bench checks every bit position and the output enable at every host rising edge. It also changes the visibility input mid-transfer and resets the block mid-transfer.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
    typedef enum logic [1:0] {
        ST_CODE  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } pgr_state_e;
endpackage

// File: rtl/pgr_edge_sync.sv
module pgr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pclk_i,
    input  logic pdat_i,
    output logic rise_o,
    output logic fall_o,
    output logic dat_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_sync;
        logic [STAGES-1:0] dat_sync;
        logic              clk_prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.clk_sync = {r_q.clk_sync[STAGES-2:0], pclk_i};
        r_d.dat_sync = {r_q.dat_sync[STAGES-2:0], pdat_i};
        r_d.clk_prev = r_q.clk_sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rise_o = r_q.clk_sync[STAGES-1] & ~r_q.clk_prev;
    assign fall_o = ~r_q.clk_sync[STAGES-1] & r_q.clk_prev;
    assign dat_o  = r_q.dat_sync[STAGES-1];
endmodule

// File: rtl/pgr_core.sv
module pgr_core
    import pgr_pkg::*;
#(
    parameter int              CODE_W    = 4,
    parameter int              DATA_W    = 16,
    parameter int              IDLE_CYC  = 8,
    parameter logic [CODE_W-1:0] READ_CODE = 4'b0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              dat_i,
    input  logic [DATA_W-1:0] vis_i,
    output logic              dout_o,
    output logic              oe_o
);
    localparam int MAX_A = (CODE_W > DATA_W) ? CODE_W : DATA_W;
    localparam int MAX_N = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        pgr_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] shadow;
        logic              dout;
        logic              oe;
    } core_t;

    core_t r_d, r_q;
    logic [CODE_W-1:0] code_next;

    always_comb begin
        r_d       = r_q;
        code_next = {dat_i, r_q.code[CODE_W-1:1]};
        unique case (r_q.state)
            ST_CODE: begin
                if (rise_i) begin
                    r_d.code = code_next;
                    if (r_q.cnt == CODE_LAST) begin
                        r_d.cnt = '0;
                        if (code_next == READ_CODE) r_d.state = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (rise_i) begin
                    if (r_q.cnt == IDLE_LAST) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_SHIFT;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (fall_i) begin
                    if (!r_q.oe) begin
                        r_d.oe     = 1'b1;
                        r_d.dout   = vis_i[0];
                        r_d.shadow = vis_i >> 1;
                    end else begin
                        r_d.dout   = r_q.shadow[0];
                        r_d.shadow = r_q.shadow >> 1;
                    end
                end
                if (rise_i && r_q.oe) begin
                    if (r_q.cnt == DATA_LAST) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_HOLD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (rise_i) begin
                    r_d.oe    = 1'b0;
                    r_d.dout  = 1'b0;
                    r_d.state = ST_CODE;
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign dout_o = r_q.dout;
    assign oe_o   = r_q.oe;
endmodule

// File: rtl/pgr_readout.sv
module pgr_readout #(
    parameter int CODE_W      = 4,
    parameter int DATA_W      = 16,
    parameter int IDLE_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_i,
    input  logic              pdat_i,
    input  logic [DATA_W-1:0] vis_i,
    output logic              pdat_o,
    output logic              pdat_oe_o
);
    localparam logic [CODE_W-1:0] READ_CODE = CODE_W'(1);

    logic rise_w;
    logic fall_w;
    logic dat_w;

    pgr_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pclk_i (pclk_i),
        .pdat_i (pdat_i),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .dat_o  (dat_w)
    );

    pgr_core #(
        .CODE_W   (CODE_W),
        .DATA_W   (DATA_W),
        .IDLE_CYC (IDLE_CYC),
        .READ_CODE(READ_CODE)
    ) i_core (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise_w),
        .fall_i (fall_w),
        .dat_i  (dat_w),
        .vis_i  (vis_i),
        .dout_o (pdat_o),
        .oe_o   (pdat_oe_o)
    );
endmodule

// File: rtl/pgr_readout_chk.sv
module pgr_readout_chk (
    input logic clk,
    input logic rst,
    input logic rise,
    input logic fall,
    input logic dout,
    input logic oe
);
    p_released_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!oe && !dout));

    p_dout_low_when_released_r1: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !dout);

    p_drive_starts_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(fall));

    p_release_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(oe) && !$past(rst)) |-> $past(rise));

    p_bit_held_between_falls_r4: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe) && !$past(fall) && !$past(rst)) |-> $stable(dout));
endmodule

bind pgr_readout pgr_readout_chk i_chk (
    .clk  (clk),
    .rst  (rst),
    .rise (rise_w),
    .fall (fall_w),
    .dout (pdat_o),
    .oe   (pdat_oe_o)
);

// File: tb/test_pgr_readout.sv
`timescale 1ns/1ps
module test_pgr_readout;
    localparam int HALF   = 8;
    localparam int DATA_W = 16;
    localparam int IDLE_N = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pclk = 1'b0;
    logic              pdat = 1'b0;
    logic [DATA_W-1:0] vis = '0;
    logic              dout;
    logic              oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pgr_readout i_pgr_readout (
        .clk       (clk),
        .rst       (rst),
        .pclk_i    (pclk),
        .pdat_i    (pdat),
        .vis_i     (vis),
        .pdat_o    (dout),
        .pdat_oe_o (oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One host clock: drive data while low, sample just before the rise and just before the fall.
    task automatic hcyc(input logic b, output logic d_pre, output logic oe_pre, output logic oe_post);
        pdat = b;
        repeat (HALF) @(negedge clk);
        d_pre  = dout;
        oe_pre = oe;
        pclk = 1'b1;
        repeat (HALF) @(negedge clk);
        oe_post = oe;
        pclk = 1'b0;
    endtask

    task automatic send_code(input logic [3:0] c, input string req);
        logic d, o1, o2;
        for (int i = 0; i < 4; i++) begin
            hcyc(c[i], d, o1, o2);
            chk(o1 == 1'b0 && o2 == 1'b0, req, {o1, o2}, 0);
        end
    endtask

    // R2 R3 R4 R6: full readout; if swap_at >= 0 vis changes after that bit (R5)
    task automatic readout(input logic [DATA_W-1:0] w, input int swap_at);
        logic d, o1, o2;
        vis = w;
        send_code(4'b0001, "R2/R3 code");
        for (int i = 0; i < IDLE_N; i++) begin
            hcyc(1'b0, d, o1, o2);
            chk(o1 == 1'b0 && o2 == 1'b0, "R3 idle", {o1, o2}, 0);
        end
        for (int i = 0; i < DATA_W; i++) begin
            hcyc(1'b0, d, o1, o2);
            chk(o1 == 1'b1, "R4 oe", o1, 1);
            chk(d == w[i], (swap_at >= 0) ? "R5 bit" : "R4 bit", d, w[i]);
            if (i == swap_at) vis = ~w;
        end
        chk(o2 == 1'b1, "R6 hold after last", o2, 1);
        hcyc(1'b0, d, o1, o2);
        chk(o1 == 1'b1 && d == w[DATA_W-1], "R6 turnaround", {o1, d}, {1'b1, w[DATA_W-1]});
        chk(o2 == 1'b0, "R6 release", o2, 0);
    endtask

    initial begin
        logic d, o1, o2;
        repeat (4) @(negedge clk);
        chk(oe == 1'b0 && dout == 1'b0, "R1 during reset", {oe, dout}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(oe == 1'b0 && dout == 1'b0, "R1 after reset", {oe, dout}, 0);

        readout(16'hA5C3, -1);
        readout(16'h0000, -1);
        readout(16'hFFFF, -1);
        for (int k = 0; k < DATA_W; k++) readout(16'(1 << k), -1);
        for (int k = 1; k < 6; k++) readout(16'(k * 16'h1357 + 16'h0F0F), -1);

        // R7 R2: every other code is discarded and a readout follows at once
        for (int c = 0; c < 16; c++) begin
            if (c == 1) continue;
            send_code(4'(c), "R7 ignored code");
            chk(oe == 1'b0, "R7 still released", oe, 0);
            readout(16'(c * 16'h0421 + 16'h8001), -1);
        end

        // R5 shadow capture
        readout(16'h3C96, 0);
        readout(16'hE11D, 7);

        // R8 reset mid transfer
        vis = 16'h5A5A;
        send_code(4'b0001, "R8 code");
        for (int i = 0; i < IDLE_N + 5; i++) hcyc(1'b0, d, o1, o2);
        chk(oe == 1'b1, "R8 driving before reset", oe, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(oe == 1'b0 && dout == 1'b0, "R8 released", {oe, dout}, 0);
        readout(16'h7E81, -1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule